// File: doc/BRIEF.md
# SDRAM Bring-up and Refresh Sequencer

This block brings an SDRAM array from an unconfigured state to normal operation and then keeps it refreshed. After reset it stays quiet, with the clock-enable low, until software raises an enable. It then offers a fixed series of commands on a command stream: one precharge of all banks, eight auto-refresh commands, and one mode-register load. When the last wait has elapsed it pulses a completion flag and declares the memory ready. The periodic refresh timer starts as soon as the precharge-all is accepted.

Once ready, the block raises refresh requests at a programmable interval of (RC + 1) × 16 clocks. Requests that arrive while the data path holds the bus are counted, so none is lost, and they are offered back to back once the bus is granted again. The block also tells the data path when an ACTIVATE is allowed, which is not the case during the programmed refresh-to-activate gap. A sleep request drops the clock-enable, and the memory then refreshes itself.

Commands leave on a valid/ready stream. The arbiter for the data path drives `cmd_ready` high to grant the bus. While `cmd_valid` is high and `cmd_ready` is low, the command and its address stay unchanged. A command is issued in a cycle where both are high. The block never withdraws a command it has offered. All timing inputs are expected to be held steady while the block is out of reset.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: While reset is held, and afterwards for as long as `cfg_enable` stays low, `cmd_valid`, `mem_cke`, `init_done`, `mem_ready` and `act_ok` are all 0.
- R2: The first command after enable is precharge-all, with code 0 and address bit 10 set (address 0x400). `mem_cke` rises in the same cycle that this command is first offered.
- R3: Exactly eight auto-refresh commands (code 1, address 0) follow the precharge-all. The first is offered `cfg_t_rp` cycles after the precharge-all is issued, and each later one `cfg_t_rc` cycles after the one before.
- R4: The mode-register load (code 2) is offered `cfg_t_rc` cycles after the eighth refresh. Its address carries `cfg_mode[9:0]` unchanged, with bits 11:10 forced to 0.
- R5: `init_done` is high for exactly one cycle, `cfg_t_mrd` cycles after the mode load is issued. `mem_ready` is high from the next cycle on.
- R6: A refresh tick occurs every (`cfg_rc` + 1) × 16 cycles, counted from the cycle in which the precharge-all is issued.
- R7: Every tick that occurs while `mem_cke` is high, including those during bring-up, is later issued as one auto-refresh (code 1) once the memory is ready. Up to 2^PEND_W − 1 ticks may be outstanding, and none is dropped.
- R8: `act_ok` is high only when the memory is ready and awake and no refresh-to-activate gap is running. It is low for `cfg_t_rc` cycles after every refresh issued in normal operation.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_code` and `cmd_addr` keep their values in the next cycle.
- R10: With `sleep_req` high in normal operation and no refresh outstanding, `mem_cke` falls on the next cycle and no command is offered while it is low. Ticks during sleep are not counted. `mem_cke` rises on the cycle after `sleep_req` falls.
- R11: Once bring-up has started, `cfg_enable` has no further effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Start of bring-up, sampled only while idle |
| cfg_rc | input | RC_W | Refresh count field; the period is (value+1)×16 clocks |
| cfg_t_rp | input | DLY_W | Wait in clocks after precharge-all |
| cfg_t_rc | input | DLY_W | Gap in clocks after each auto-refresh |
| cfg_t_mrd | input | DLY_W | Wait in clocks after the mode-register load |
| cfg_mode | input | MODE_W | Mode word; bits 11:10 are ignored |
| sleep_req | input | 1 | Request for power-down with self-refresh |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | Bus granted; the offered command is issued |
| cmd_code | output | 2 | 0 precharge-all, 1 auto-refresh, 2 mode load, 3 none |
| cmd_addr | output | MODE_W | Address pins for the command |
| act_ok | output | 1 | An ACTIVATE is allowed |
| mem_cke | output | 1 | Clock-enable to the memory |
| init_done | output | 1 | One-cycle pulse at the end of bring-up |
| mem_ready | output | 1 | Memory is in normal operation |

## Verification
The sequence state, wait counter, refresh timer and pending counter are only visible through the command stream. A wrong sequence state shows up as a wrong command code or address, or as a missing or extra refresh, in the very cycle the reference model expects something else. A wait counter that is off by one moves `cmd_valid`, `init_done` or `act_ok` by one cycle, and this is caught on that cycle. A timer or pending-count error appears within one refresh period as a wrong spacing, or as a refresh total that differs from the number of ticks once the bus is released.

// File: rtl/sris_pkg.sv
package sris_pkg;
  typedef enum logic [1:0] {
    CMD_PALL = 2'd0,
    CMD_AREF = 2'd1,
    CMD_LMR  = 2'd2,
    CMD_NOP  = 2'd3
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_PALL,
    ST_IREF,
    ST_LMR,
    ST_MRD,
    ST_RUN
  } seq_st_e;

  // address bit that selects all banks during a precharge
  localparam int ALLBANK_BIT = 10;
  // low bits of the mode word that reach the pins
  localparam int MODE_KEEP = 10;
endpackage

// File: rtl/sris_tick_gen.sv
module sris_tick_gen #(
  parameter int RC_W  = 8,
  parameter int PRE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [RC_W-1:0] rc,
  output logic            tick
);
  logic             on;
  logic [PRE_W-1:0] pre;
  logic [RC_W-1:0]  left;
  logic             wrap;

  assign wrap = on && (pre == {PRE_W{1'b1}});
  assign tick = wrap && (left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on   <= 1'b0;
      pre  <= '0;
      left <= '0;
    end else if (start) begin
      on   <= 1'b1;
      pre  <= '0;
      left <= rc;
    end else if (on) begin
      pre <= pre + 1'b1;
      if (wrap) left <= (left == '0) ? rc : left - 1'b1;
    end
  end
endmodule

// File: rtl/sris_gap_ctr.sv
module sris_gap_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         idle
);
  logic [W-1:0] cnt;

  assign idle = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= val;
    else if (!idle)    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sris_pend_ctr.sv
module sris_pend_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         nonzero
);
  assign nonzero = (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)              count <= '0;
    else if (inc && !dec)    count <= count + 1'b1;
    else if (dec && !inc)    count <= count - 1'b1;
  end
endmodule

// File: rtl/sdram_init_refresh_seq.sv
module sdram_init_refresh_seq
  import sris_pkg::*;
#(
  parameter int RC_W      = 8,
  parameter int DLY_W     = 4,
  parameter int PEND_W    = 3,
  parameter int MODE_W    = 12,
  parameter int INIT_REFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [RC_W-1:0]   cfg_rc,
  input  logic [DLY_W-1:0]  cfg_t_rp,
  input  logic [DLY_W-1:0]  cfg_t_rc,
  input  logic [DLY_W-1:0]  cfg_t_mrd,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              sleep_req,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_code,
  output logic [MODE_W-1:0] cmd_addr,
  output logic              act_ok,
  output logic              mem_cke,
  output logic              init_done,
  output logic              mem_ready
);
  localparam int REF_W = (INIT_REFS > 1) ? $clog2(INIT_REFS) : 1;
  localparam logic [REF_W-1:0]  LAST_REF  = REF_W'(INIT_REFS - 1);
  localparam logic [MODE_W-1:0] MODE_MASK = MODE_W'((1 << MODE_KEEP) - 1);
  localparam logic [MODE_W-1:0] PALL_ADDR = MODE_W'(1 << ALLBANK_BIT);

  seq_st_e          st;
  logic [REF_W-1:0] nref;
  logic             cke_q;
  logic             accept;
  logic             gap_idle;
  logic [DLY_W-1:0] gap_val;
  logic             tick;
  logic             tmr_start;
  logic             pend_inc;
  logic             pend_dec;
  logic             pend_nz;
  logic [PEND_W-1:0] pend_cnt;

  assign accept    = cmd_valid && cmd_ready;
  assign tmr_start = accept && (st == ST_PALL);
  assign pend_inc  = tick && cke_q;
  assign pend_dec  = accept && (st == ST_RUN);

  assign mem_cke   = cke_q;
  assign mem_ready = (st == ST_RUN);
  assign init_done = (st == ST_MRD) && gap_idle;
  assign act_ok    = (st == ST_RUN) && gap_idle && cke_q;

  // command offer
  always_comb begin
    cmd_valid = 1'b0;
    cmd_code  = CMD_NOP;
    cmd_addr  = '0;
    unique case (st)
      ST_PALL: begin
        cmd_valid = 1'b1;
        cmd_code  = CMD_PALL;
        cmd_addr  = PALL_ADDR;
      end
      ST_IREF: begin
        cmd_valid = gap_idle;
        cmd_code  = CMD_AREF;
      end
      ST_LMR: begin
        cmd_valid = gap_idle;
        cmd_code  = CMD_LMR;
        cmd_addr  = cfg_mode & MODE_MASK;
      end
      ST_RUN: begin
        cmd_valid = gap_idle && pend_nz && cke_q;
        cmd_code  = CMD_AREF;
      end
      default: ;
    endcase
  end

  // wait length loaded when a command is issued
  always_comb begin
    unique case (st)
      ST_PALL: gap_val = cfg_t_rp;
      ST_LMR:  gap_val = cfg_t_mrd;
      default: gap_val = cfg_t_rc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_OFF;
      nref  <= '0;
      cke_q <= 1'b0;
    end else begin
      unique case (st)
        ST_OFF: if (cfg_enable) begin
          st    <= ST_PALL;
          cke_q <= 1'b1;
        end
        ST_PALL: if (accept) begin
          st   <= ST_IREF;
          nref <= '0;
        end
        ST_IREF: if (accept) begin
          nref <= nref + 1'b1;
          if (nref == LAST_REF) st <= ST_LMR;
        end
        ST_LMR: if (accept) st <= ST_MRD;
        ST_MRD: if (gap_idle) st <= ST_RUN;
        ST_RUN: begin
          if (sleep_req && !pend_nz) cke_q <= 1'b0;
          else if (!sleep_req)       cke_q <= 1'b1;
        end
        default: st <= ST_OFF;
      endcase
    end
  end

  sris_gap_ctr #(.W(DLY_W)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .val   (gap_val),
    .idle  (gap_idle)
  );

  sris_tick_gen #(.RC_W(RC_W), .PRE_W(4)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .rc    (cfg_rc),
    .tick  (tick)
  );

  sris_pend_ctr #(.W(PEND_W)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (pend_inc),
    .dec     (pend_dec),
    .count   (pend_cnt),
    .nonzero (pend_nz)
  );
endmodule

// File: rtl/sris_checker.sv
module sris_checker #(
  parameter int PEND_W = 3,
  parameter int MODE_W = 12,
  parameter int DLY_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_code,
  input logic [MODE_W-1:0] cmd_addr,
  input logic              act_ok,
  input logic              mem_cke,
  input logic              init_done,
  input logic              mem_ready,
  input logic [DLY_W-1:0]  cfg_t_rc,
  input logic              pend_inc,
  input logic              pend_dec,
  input logic [PEND_W-1:0] pend_cnt
);
  // R9: an offered command is held until granted
  a_r9_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_addr));

  // R1 and R10: with clock-enable low nothing is offered
  a_r10_quiet_when_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cke |-> !cmd_valid);

  // R2: the first offer after enable is precharge-all
  a_r2_first_is_pall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke) && !mem_ready |-> cmd_valid && cmd_code == 2'd0);

  // R4: the two top mode bits never reach the pins
  a_r4_mode_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 2'd2 |-> cmd_addr[MODE_W-1:10] == '0);

  // R5: the completion flag is a single pulse followed by ready
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> !init_done && mem_ready);

  // R8: no activate right after a refresh
  a_r8_gap_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_code == 2'd1 && mem_ready && cfg_t_rc != '0 |=> !act_ok);

  // R7: the pending count never wraps
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    pend_inc && !pend_dec |-> pend_cnt != {PEND_W{1'b1}});
endmodule

bind sdram_init_refresh_seq sris_checker #(
  .PEND_W (PEND_W),
  .MODE_W (MODE_W),
  .DLY_W  (DLY_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_code  (cmd_code),
  .cmd_addr  (cmd_addr),
  .act_ok    (act_ok),
  .mem_cke   (mem_cke),
  .init_done (init_done),
  .mem_ready (mem_ready),
  .cfg_t_rc  (cfg_t_rc),
  .pend_inc  (pend_inc),
  .pend_dec  (pend_dec),
  .pend_cnt  (pend_cnt)
);

// File: tb/sdram_init_refresh_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_refresh_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [7:0]  cfg_rc = 8'd0;
  logic [3:0]  cfg_t_rp = 4'd2;
  logic [3:0]  cfg_t_rc = 4'd3;
  logic [3:0]  cfg_t_mrd = 4'd2;
  logic [11:0] cfg_mode = 12'hE20;
  logic        sleep_req = 1'b0;
  logic        cmd_ready = 1'b0;
  logic        cmd_valid, act_ok, mem_cke, init_done, mem_ready;
  logic [1:0]  cmd_code;
  logic [11:0] cmd_addr;

  always #2.5 clk = ~clk;

  sdram_init_refresh_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_rc(cfg_rc),
    .cfg_t_rp(cfg_t_rp), .cfg_t_rc(cfg_t_rc), .cfg_t_mrd(cfg_t_mrd),
    .cfg_mode(cfg_mode), .sleep_req(sleep_req), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .act_ok(act_ok), .mem_cke(mem_cke), .init_done(init_done),
    .mem_ready(mem_ready)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // ---------------- reference model ----------------
  int m_ph, m_wt, m_nref, m_pend, m_left, m_ticks;
  bit m_ton, m_cke;

  function automatic bit m_valid();
    case (m_ph)
      1: return 1'b1;
      2, 3: return m_wt == 0;
      5: return m_pend > 0 && m_wt == 0 && m_cke;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int m_code();
    case (m_ph)
      1: return 0;
      3: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int m_addr();
    case (m_ph)
      1: return 12'h400;
      3: return int'(cfg_mode) & 12'h3FF;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
    if (!rst_n) begin
      m_ph = 0; m_wt = 0; m_nref = 0; m_pend = 0; m_left = 0;
      m_ticks = 0; m_ton = 0; m_cke = 0;
    end else begin
      bit acc, tk;
      int old_wt, old_pend;
      acc = m_valid() && cmd_ready;
      tk = 0;
      old_wt = m_wt;
      old_pend = m_pend;
      if (m_ton) begin
        m_left--;
        if (m_left == 0) begin tk = 1; m_left = (int'(cfg_rc) + 1) * 16; end
      end
      if (tk && m_cke) begin m_pend++; m_ticks++; end
      if (m_ph == 5 && acc) m_pend--;
      if (acc) m_wt = (m_ph == 1) ? int'(cfg_t_rp) : (m_ph == 3) ? int'(cfg_t_mrd) : int'(cfg_t_rc);
      else if (m_wt > 0) m_wt--;
      case (m_ph)
        0: if (cfg_enable) begin m_ph = 1; m_cke = 1; end
        1: if (acc) begin m_ph = 2; m_nref = 0; m_ton = 1; m_left = (int'(cfg_rc) + 1) * 16; end
        2: if (acc) begin m_nref++; if (m_nref == 8) m_ph = 3; end
        3: if (acc) m_ph = 4;
        4: if (old_wt == 0) m_ph = 5;
        5: begin
          if (sleep_req && old_pend == 0) m_cke = 0;
          else if (!sleep_req) m_cke = 1;
        end
        default: ;
      endcase
    end
  end

  // ---------------- per-cycle comparison and event log ----------------
  int n_iref, n_lmr, n_rref, lmr_addr, last_ref_cyc, ref_gap;
  always @(negedge clk) begin
    if (!rst_n) begin
      n_iref = 0; n_lmr = 0; n_rref = 0; lmr_addr = -1; last_ref_cyc = 0; ref_gap = 0;
    end else begin
      bit ev;
      ev = m_valid();
      chk("R9 cmd_valid", int'(cmd_valid), int'(ev));
      if (ev) begin
        string t;
        t = (m_ph == 1) ? "R2" : (m_ph == 2) ? "R3" : (m_ph == 3) ? "R4" : "R7";
        chk({t, " cmd_code"}, int'(cmd_code), m_code());
        chk({t, " cmd_addr"}, int'(cmd_addr), m_addr());
      end
      chk("R5 init_done", int'(init_done), int'(m_ph == 4 && m_wt == 0));
      chk("R5 mem_ready", int'(mem_ready), int'(m_ph == 5));
      chk("R8 act_ok", int'(act_ok), int'(m_ph == 5 && m_wt == 0 && m_cke));
      chk("R10 mem_cke", int'(mem_cke), int'(m_cke));
      if (cmd_valid && cmd_ready) begin
        if (cmd_code == 2'd1 && !mem_ready) n_iref++;
        if (cmd_code == 2'd2) begin n_lmr++; lmr_addr = int'(cmd_addr); end
        if (cmd_code == 2'd1 && mem_ready) begin
          n_rref++;
          ref_gap = cyc - last_ref_cyc;
          last_ref_cyc = cyc;
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !mem_ready; i++) step(1);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int snap;
    step(4);
    // R1: reset state
    chk("R1 reset cmd_valid", int'(cmd_valid), 0);
    chk("R1 reset mem_cke", int'(mem_cke), 0);
    chk("R1 reset mem_ready", int'(mem_ready), 0);
    chk("R1 reset act_ok", int'(act_ok), 0);
    rst_n = 1'b1;
    step(20);                       // R1: disabled, model expects silence
    chk("R1 idle cmd_valid", int'(cmd_valid), 0);
    cfg_enable = 1'b1;
    step(4);                        // R9: precharge-all held without grant
    cmd_ready = 1'b1;
    wait_ready();
    chk("R3 refreshes before mode load", n_iref, 8);
    chk("R4 mode load count", n_lmr, 1);
    chk("R4 mode load address", lmr_addr, 12'h220);
    step(200);
    chk("R6 refresh spacing rc=0", ref_gap, 16);
    // R11: enable dropped after start has no effect
    cfg_enable = 1'b0;
    step(30);
    chk("R11 still ready", int'(mem_ready), 1);
    // R7: hold the bus so ticks pile up, then release
    cmd_ready = 1'b0;
    step(90);
    cmd_ready = 1'b1;
    step(60);
    chk("R7 every tick serviced", n_rref, m_ticks);
    // R10: sleep
    sleep_req = 1'b1;
    step(3);
    snap = n_rref;
    chk("R10 cke low in sleep", int'(mem_cke), 0);
    step(80);
    chk("R10 no refresh in sleep", n_rref, snap);
    sleep_req = 1'b0;
    step(100);
    chk("R10 cke back", int'(mem_cke), 1);
    chk("R7 all serviced after sleep", n_rref, m_ticks);

    // second configuration: zero waits, longer period
    rst_n = 1'b0;
    cfg_rc = 8'd2; cfg_t_rp = 4'd0; cfg_t_rc = 4'd0; cfg_t_mrd = 4'd0; cfg_mode = 12'h3FF;
    cfg_enable = 1'b1;
    step(3);
    chk("R1 reset again", int'(mem_ready), 0);
    rst_n = 1'b1;
    wait_ready();
    chk("R3 refreshes zero gap", n_iref, 8);
    chk("R4 mode address all ones", lmr_addr, 12'h3FF);
    step(300);
    chk("R6 refresh spacing rc=2", ref_gap, 48);
    chk("R7 serviced rc=2", n_rref, m_ticks);
    finish_run();
  end
endmodule